// File: doc/BRIEF.md
# Four-bit accumulator with instruction-specific carry

This block holds the working accumulator of a small 4-bit controller, together with its carry flag. On each execute strobe it applies one instruction to the accumulator: a logical AND, OR or XOR with an operand, a circular or zero-filling rotate left, an increment, a carry-adjust step, or a load of the operand. A load can come either from a move or from a port read. The sequencer that fetches instructions drives the opcode, the operand and the strobe. It reads back the accumulator and the carry on the next cycle.

The carry does not follow ordinary adder rules. The logical operations AND and XOR derive it from the top bits of the two inputs. OR and both kinds of load always clear it. The rotates capture the bit that leaves the top of the accumulator. Increment and carry-adjust report a wrap from 0xF. Opcodes that are not defined leave both the accumulator and the carry unchanged.

Top module: `accum_carry_unit`

## Requirements
- R1: With AND (opcode 2) or XOR (opcode 4) strobed, the accumulator becomes acc&operand or acc^operand. Carry becomes 1 exactly when accumulator bit 3 and operand bit 3 were both 1.
- R2: With OR (opcode 3) strobed, the accumulator becomes acc|operand and carry becomes 0.
- R3: The circular rotate (opcode 5) gives {acc[2:0],acc[3]}. Carry takes the old acc[3].
- R4: The zero-fill rotate (opcode 6) gives {acc[2:0],0}. Carry takes the old acc[3].
- R5: Increment (opcode 7) adds one modulo 16. Carry becomes 1 exactly when the old value was 0xF.
- R6: Carry-adjust (opcode 8) gives the same accumulator and carry result as increment.
- R7: Move (opcode 0) and port read (opcode 1) load the operand into the accumulator and clear carry.
- R8: While the execute strobe is low, the accumulator and carry hold, whatever the opcode and operand are.
- R9: Opcodes 9 to 15 leave the accumulator and carry unchanged, even when strobed.
- R10: Reset, which is asynchronous and active low, clears the accumulator and the carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | Execute strobe; one instruction per high cycle |
| op_i | input | 4 | Instruction select (encoding in R1 to R9) |
| opnd_i | input | 4 | Operand, or port data for a port read |
| acc_o | output | 4 | Accumulator value |
| cy_o | output | 1 | Carry flag |

## Verification
The hardest state to reach from the ports is a set carry that must then survive an idle strobe or an undefined opcode. Every load clears the carry, so a load cannot set up that state directly. The stimulus first loads a value with bit 3 set and then rotates it circularly. This leaves an odd accumulator with the carry at 1. Undefined opcodes and idle cycles with an active opcode on the bus are then applied on top of that state. Apart from this, every opcode is swept against every starting value and every operand.

// File: rtl/accum_carry_unit.sv
module accum_carry_unit #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         exec_i,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] opnd_i,
  output logic [W-1:0] acc_o,
  output logic         cy_o
);
  localparam logic [3:0] OP_MOV  = 4'd0;
  localparam logic [3:0] OP_IN   = 4'd1;
  localparam logic [3:0] OP_AND  = 4'd2;
  localparam logic [3:0] OP_OR   = 4'd3;
  localparam logic [3:0] OP_XOR  = 4'd4;
  localparam logic [3:0] OP_ROTC = 4'd5;
  localparam logic [3:0] OP_ROTZ = 4'd6;
  localparam logic [3:0] OP_INC  = 4'd7;
  localparam logic [3:0] OP_ADJ  = 4'd8;

  logic [W-1:0] acc_q, acc_d;
  logic         cy_q, cy_d;

  wire top_both = acc_q[W-1] & opnd_i[W-1];

  always_comb begin
    acc_d = acc_q;
    cy_d  = cy_q;
    case (op_i)
      OP_MOV, OP_IN: begin acc_d = opnd_i;          cy_d = 1'b0; end
      OP_AND:        begin acc_d = acc_q & opnd_i;  cy_d = top_both; end
      OP_OR:         begin acc_d = acc_q | opnd_i;  cy_d = 1'b0; end
      OP_XOR:        begin acc_d = acc_q ^ opnd_i;  cy_d = top_both; end
      OP_ROTC:       begin acc_d = {acc_q[W-2:0], acc_q[W-1]}; cy_d = acc_q[W-1]; end
      OP_ROTZ:       begin acc_d = {acc_q[W-2:0], 1'b0};       cy_d = acc_q[W-1]; end
      OP_INC, OP_ADJ: begin acc_d = acc_q + 1'b1;   cy_d = &acc_q; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      acc_q <= '0;
      cy_q  <= 1'b0;
    end else if (exec_i) begin
      acc_q <= acc_d;
      cy_q  <= cy_d;
    end

  assign acc_o = acc_q;
  assign cy_o  = cy_q;

  p_logic_cy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && (op_i == OP_AND || op_i == OP_XOR)
    |=> cy_o == ($past(acc_o[W-1]) & $past(opnd_i[W-1])));

  p_or_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && op_i == OP_OR |=> !cy_o && acc_o == ($past(acc_o) | $past(opnd_i)));

  p_rot_cy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && (op_i == OP_ROTC || op_i == OP_ROTZ) |=> cy_o == $past(acc_o[W-1]));

  p_rotz_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && op_i == OP_ROTZ |=> !acc_o[0]);

  p_inc_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && (op_i == OP_INC || op_i == OP_ADJ)
    |=> acc_o == W'($past(acc_o) + 1) && cy_o == ($past(acc_o) == {W{1'b1}}));

  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && (op_i == OP_MOV || op_i == OP_IN) |=> !cy_o && acc_o == $past(opnd_i));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_i |=> $stable(acc_o) && $stable(cy_o));

  p_undef_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_i > OP_ADJ |=> $stable(acc_o) && $stable(cy_o));
endmodule

// File: tb/accum_carry_unit_tb_top.sv
module accum_carry_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exec_i = 1'b0;
  logic [3:0] op_i = 4'd0;
  logic [3:0] opnd_i = 4'd0;
  logic [3:0] acc_o;
  logic cy_o;
  int checks = 0;
  int errors = 0;

  accum_carry_unit #(.W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_i(op_i),
    .opnd_i(opnd_i), .acc_o(acc_o), .cy_o(cy_o));

  always #5 clk = ~clk;

  task automatic chk(string req, logic [3:0] ea, logic ec);
    checks++;
    if (acc_o !== ea || cy_o !== ec) begin
      errors++;
      $display("FAIL %s acc=%h cy=%b expected acc=%h cy=%b", req, acc_o, cy_o, ea, ec);
    end
  endtask

  task automatic run(logic [3:0] o, logic [3:0] b);
    @(negedge clk);
    op_i = o; opnd_i = b; exec_i = 1'b1;
    @(negedge clk);
    exec_i = 1'b0;
  endtask

  function automatic string req_of(logic [3:0] o);
    case (o)
      4'd0, 4'd1: return "R7";
      4'd2, 4'd4: return "R1";
      4'd3: return "R2";
      4'd5: return "R3";
      4'd6: return "R4";
      4'd7: return "R5";
      4'd8: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic model(logic [3:0] o, logic [3:0] a, logic [3:0] b, logic c,
                       output logic [3:0] ea, output logic ec);
    ea = a; ec = c;
    case (o)
      4'd0, 4'd1: begin ea = b; ec = 1'b0; end
      4'd2: begin ea = a & b; ec = (a >= 8) && (b >= 8); end
      4'd3: begin ea = a | b; ec = 1'b0; end
      4'd4: begin ea = a ^ b; ec = (a >= 8) && (b >= 8); end
      4'd5: begin ea = 4'((a * 2) % 16 + a / 8); ec = (a >= 8); end
      4'd6: begin ea = 4'((a * 2) % 16); ec = (a >= 8); end
      4'd7, 4'd8: begin ea = 4'((a + 1) % 16); ec = (a == 15); end
      default: ;
    endcase
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog run incomplete acc=%h cy=%b expected completion", acc_o, cy_o);
    finish_run();
  end

  initial begin
    logic [3:0] ea;
    logic ec;
    repeat (3) @(negedge clk);
    chk("R10", 4'h0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", 4'h0, 1'b0);

    for (int o = 0; o < 16; o++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          run(4'd0, 4'(a));
          run(4'(o), 4'(b));
          model(4'(o), 4'(a), 4'(b), 1'b0, ea, ec);
          chk(req_of(4'(o)), ea, ec);
        end

    for (int a = 8; a < 16; a++) begin
      run(4'd0, 4'(a));
      run(4'd5, 4'd0);
      model(4'd5, 4'(a), 4'd0, 1'b0, ea, ec);
      chk("R3", ea, ec);
      for (int o = 9; o < 16; o++) begin
        run(4'(o), 4'(15 - a));
        chk("R9", ea, 1'b1);
      end
      @(negedge clk);
      op_i = 4'd0; opnd_i = 4'd0;
      repeat (3) @(negedge clk);
      chk("R8", ea, 1'b1);
      op_i = 4'd7;
      @(negedge clk);
      chk("R8", ea, 1'b1);
    end

    run(4'd0, 4'hF);
    run(4'd8, 4'd0);
    chk("R6", 4'h0, 1'b1);
    run(4'd8, 4'd0);
    chk("R6", 4'h1, 1'b0);

    run(4'd0, 4'hA);
    run(4'd5, 4'd0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10", 4'h0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", 4'h0, 1'b0);

    finish_run();
  end
endmodule